// File: doc/BRIEF.md
# Scan Chain with Vector Hold Registers

This block is a chain of test flip-flops that serves three purposes. It captures functional data in normal operation. It shifts a test vector in from a serial input. It can also restore a stored vector into every cell in one clock. Each cell picks its next value from three sources: the functional input, the scan path, or a hold line. The hold line is fed by a hold register that keeps a copy of the vector.

A typical sequence is as follows. Shift a vector in. Pulse the hold-load control once. Then run as many capture/restore rounds as the measurement needs, with no further shifting. The cells are grouped into clusters of equal size, and the last cluster takes whatever cells remain. The tail cell of each cluster feeds the head of the next cluster. It also drives a per-cluster response output, which goes to that cluster's response compactor.

One hold register may serve a group of neighbouring cells. It samples the first cell of its group, and its output drives the hold line of every cell in the group. Flop reset clears the cells only. The hold registers keep their contents through it.

Top module: `vhold_scan_chain`

## Requirements
- R1: While `rst_n` is low, every cell output `cell_q` is 0. `scan_out` and `cluster_resp` are 0 as well.
- R2: With `test_mode`=0, each cell loads its bit of `func_d` at the rising clock edge.
- R3: With `test_mode`=1 and `hold_restore`=0, the chain shifts toward higher indices. Cell 0 loads `scan_in`, and cell i loads the old value of cell i-1. `scan_out` always equals cell NUM_CELLS-1.
- R4: With `test_mode`=1 and `hold_restore`=1, every cell loads its hold line in a single clock.
- R5: `hold_load`=1 at an edge stores the cell values present just before that edge. This happens in any mode. With `hold_load`=0, the stored vector does not change, whatever the cells do.
- R6: The stored vector can be restored any number of times. A flop reset does not erase it.
- R7: Cluster c covers cells c*CLUSTER_SIZE upward. Its tail is min((c+1)*CLUSTER_SIZE, NUM_CELLS)-1, and `cluster_resp[c]` equals that tail cell. With defaults (10 cells, size 4) the tails are cells 3, 7 and 9.
- R8: With HOLD_SHARE=S, hold register h samples cell h*S. On a restore, cell i loads the value stored from cell i-(i mod S).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for cells and hold registers |
| rst_n | input | 1 | Asynchronous active-low cell reset |
| test_mode | input | 1 | 0: functional capture; 1: scan-path source |
| hold_restore | input | 1 | In test mode: 0 shifts, 1 restores from the hold line |
| hold_load | input | 1 | Copies the cell values into the hold registers |
| func_d | input | NUM_CELLS | Functional data, one bit per cell |
| scan_in | input | 1 | Serial input to cell 0 |
| cell_q | output | NUM_CELLS | Cell outputs |
| scan_out | output | 1 | Serial output from the last cell |
| cluster_resp | output | NUM_CLUSTERS | Tail cell value of each cluster |

## Verification
The restore assertion compares the cells with their hold lines one cycle earlier. It therefore needs a vector to have been stored before the first restore. The stimulus always pulses `hold_load` ahead of any restore. The shift property needs at least two cells, and every configuration driven here has more. Inputs change only on falling clock edges, so each property sees the control values stable across the edge it judges.

// File: rtl/vhs_pkg.sv
package vhs_pkg;

  typedef enum logic [1:0] {
    CELL_FUNC   = 2'd0,
    CELL_SHIFT  = 2'd1,
    CELL_RELOAD = 2'd2
  } cell_mode_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // last cell index belonging to cluster c
  function automatic int cluster_tail(input int c, input int size, input int cells);
    int last;
    last = (c + 1) * size - 1;
    return (last > cells - 1) ? cells - 1 : last;
  endfunction

  // hold register that serves cell i
  function automatic int hold_index(input int i, input int share);
    return i / share;
  endfunction

  // cell sampled by hold register h
  function automatic int hold_leader(input int h, input int share);
    return h * share;
  endfunction

  function automatic cell_mode_e decode_mode(input logic test, input logic restore);
    if (!test) return CELL_FUNC;
    return restore ? CELL_RELOAD : CELL_SHIFT;
  endfunction

endpackage

// File: rtl/vhs_scan_cell.sv
module vhs_scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_hold,
  input  logic sel_test,
  input  logic d_func,
  input  logic d_scan,
  input  logic d_hold,
  output logic q
);
  logic upper_mux;
  logic next_q;

  // first stage: scan path or hold line
  assign upper_mux = sel_hold ? d_hold : d_scan;
  // second stage: test source or functional data
  assign next_q    = sel_test ? upper_mux : d_func;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= next_q;
  end
endmodule

// File: rtl/vhs_hold_bank.sv
module vhs_hold_bank #(
  parameter int NUM_CELLS  = 10,
  parameter int HOLD_SHARE = 1
) (
  input  logic                 clk,
  input  logic                 load,
  input  logic [NUM_CELLS-1:0] cell_q,
  output logic [NUM_CELLS-1:0] hold_line
);
  localparam int NUM_HOLDS = vhs_pkg::ceil_div(NUM_CELLS, HOLD_SHARE);

  logic [NUM_HOLDS-1:0] held;

  for (genvar h = 0; h < NUM_HOLDS; h++) begin : g_hold
    localparam int LEAD = vhs_pkg::hold_leader(h, HOLD_SHARE);
    // not cleared by cell reset: the vector survives it
    always_ff @(posedge clk) begin
      if (load) held[h] <= cell_q[LEAD];
    end
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_line
    localparam int SRC = vhs_pkg::hold_index(i, HOLD_SHARE);
    assign hold_line[i] = held[SRC];
  end
endmodule

// File: rtl/vhs_chain_router.sv
module vhs_chain_router #(
  parameter int NUM_CELLS    = 10,
  parameter int CLUSTER_SIZE = 4
) (
  input  logic                    scan_in,
  input  logic [NUM_CELLS-1:0]    cell_q,
  output logic [NUM_CELLS-1:0]    scan_path,
  output logic                    scan_out,
  output logic [vhs_pkg::ceil_div(NUM_CELLS, CLUSTER_SIZE)-1:0] cluster_resp
);
  localparam int NUM_CLUSTERS = vhs_pkg::ceil_div(NUM_CELLS, CLUSTER_SIZE);

  assign scan_path[0] = scan_in;
  for (genvar i = 1; i < NUM_CELLS; i++) begin : g_link
    assign scan_path[i] = cell_q[i-1];
  end

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_tail
    localparam int TAIL = vhs_pkg::cluster_tail(c, CLUSTER_SIZE, NUM_CELLS);
    assign cluster_resp[c] = cell_q[TAIL];
  end

  assign scan_out = cell_q[NUM_CELLS-1];
endmodule

// File: rtl/vhold_scan_chain.sv
module vhold_scan_chain #(
  parameter int NUM_CELLS    = 10,
  parameter int CLUSTER_SIZE = 4,
  parameter int HOLD_SHARE   = 1,
  localparam int NUM_CLUSTERS = vhs_pkg::ceil_div(NUM_CELLS, CLUSTER_SIZE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    test_mode,
  input  logic                    hold_restore,
  input  logic                    hold_load,
  input  logic [NUM_CELLS-1:0]    func_d,
  input  logic                    scan_in,
  output logic [NUM_CELLS-1:0]    cell_q,
  output logic                    scan_out,
  output logic [NUM_CLUSTERS-1:0] cluster_resp
);
  vhs_pkg::cell_mode_e mode;
  logic                 sel_hold;
  logic                 sel_test;
  logic [NUM_CELLS-1:0] scan_path;
  logic [NUM_CELLS-1:0] hold_line;

  assign mode     = vhs_pkg::decode_mode(test_mode, hold_restore);
  assign sel_test = (mode != vhs_pkg::CELL_FUNC);
  assign sel_hold = (mode == vhs_pkg::CELL_RELOAD);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    vhs_scan_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_hold(sel_hold),
      .sel_test(sel_test),
      .d_func  (func_d[i]),
      .d_scan  (scan_path[i]),
      .d_hold  (hold_line[i]),
      .q       (cell_q[i])
    );
  end

  vhs_hold_bank #(
    .NUM_CELLS (NUM_CELLS),
    .HOLD_SHARE(HOLD_SHARE)
  ) u_hold (
    .clk      (clk),
    .load     (hold_load),
    .cell_q   (cell_q),
    .hold_line(hold_line)
  );

  vhs_chain_router #(
    .NUM_CELLS   (NUM_CELLS),
    .CLUSTER_SIZE(CLUSTER_SIZE)
  ) u_route (
    .scan_in     (scan_in),
    .cell_q      (cell_q),
    .scan_path   (scan_path),
    .scan_out    (scan_out),
    .cluster_resp(cluster_resp)
  );
endmodule

// File: rtl/vhs_chain_checker.sv
module vhs_chain_checker #(
  parameter int NUM_CELLS = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 test_mode,
  input logic                 hold_restore,
  input logic                 hold_load,
  input logic [NUM_CELLS-1:0] func_d,
  input logic                 scan_in,
  input logic [NUM_CELLS-1:0] cell_q,
  input logic [NUM_CELLS-1:0] hold_line
);
  AST_FUNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> cell_q == $past(func_d)); // R2

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !hold_restore) |=>
      cell_q == {$past(cell_q[NUM_CELLS-2:0]), $past(scan_in)}); // R3

  AST_RELOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && hold_restore) |=> cell_q == $past(hold_line)); // R4

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_load |=> $stable(hold_line)); // R5

  AST_HOLD_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> hold_line[0] == $past(cell_q[0])); // R5
endmodule

bind vhold_scan_chain vhs_chain_checker #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .test_mode   (test_mode),
  .hold_restore(hold_restore),
  .hold_load   (hold_load),
  .func_d      (func_d),
  .scan_in     (scan_in),
  .cell_q      (cell_q),
  .hold_line   (hold_line)
);

// File: tb/vhold_scan_chain_bench.sv
module vhold_scan_chain_bench;
  localparam int N   = 10;
  localparam int CS  = 4;
  localparam int NCL = 3;
  localparam int NS  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          test_mode = 1'b0;
  logic          hold_restore = 1'b0;
  logic          hold_load = 1'b0;
  logic [N-1:0]  func_d = '0;
  logic          scan_in = 1'b0;
  logic [N-1:0]  cell_q;
  logic          scan_out;
  logic [NCL-1:0] cluster_resp;

  logic [NS-1:0] func_d_s = '0;
  logic [NS-1:0] cell_q_s;
  logic          scan_out_s;
  logic [1:0]    cluster_resp_s;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] stored_vec;

  always #10 clk = ~clk;

  vhold_scan_chain #(.NUM_CELLS(N), .CLUSTER_SIZE(CS), .HOLD_SHARE(1)) u_vhold_scan_chain (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .hold_restore(hold_restore),
    .hold_load(hold_load), .func_d(func_d), .scan_in(scan_in),
    .cell_q(cell_q), .scan_out(scan_out), .cluster_resp(cluster_resp)
  );

  vhold_scan_chain #(.NUM_CELLS(NS), .CLUSTER_SIZE(3), .HOLD_SHARE(2)) u_vhold_scan_chain_shared (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .hold_restore(hold_restore),
    .hold_load(hold_load), .func_d(func_d_s), .scan_in(scan_in),
    .cell_q(cell_q_s), .scan_out(scan_out_s), .cluster_resp(cluster_resp_s)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic apply(input logic t, input logic r, input logic ld,
                       input logic [N-1:0] d, input logic si, input logic [NS-1:0] ds);
    test_mode = t; hold_restore = r; hold_load = ld;
    func_d = d; scan_in = si; func_d_s = ds;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "cells in reset", 32'(cell_q), 0);
    check("R1", "scan_out in reset", 32'(scan_out), 0);
    check("R1", "responses in reset", 32'(cluster_resp), 0);
  endtask

  task automatic t_functional;
    logic [N-1:0] pats [3] = '{10'h2A5, 10'h15A, 10'h3FF};
    foreach (pats[k]) begin
      apply(0, 0, 0, pats[k], 1'b1, '0);
      check("R2", "functional capture", 32'(cell_q), 32'(pats[k]));
    end
    apply(0, 1, 0, 10'h0C3, 1'b0, '0);
    check("R2", "capture ignores restore select", 32'(cell_q), 32'h0C3);
  endtask

  task automatic t_shift;
    logic [N-1:0] exp;
    apply(0, 0, 0, '0, 1'b0, '0);
    exp = '0;
    for (int k = N - 1; k >= 0; k--) begin
      apply(1, 0, 0, 10'h3FF, stored_vec[k], '0);
      exp = {exp[N-2:0], stored_vec[k]};
      check("R3", "shift step", 32'(cell_q), 32'(exp));
      check("R3", "scan_out tracks last cell", 32'(scan_out), 32'(exp[N-1]));
    end
  endtask

  task automatic t_hold_restore;
    // load while capturing: hold takes the pre-edge vector
    apply(0, 0, 1, 10'h155, 1'b0, '0);
    check("R5", "capture alongside hold load", 32'(cell_q), 32'h155);
    apply(1, 1, 0, '0, 1'b0, '0);
    check("R4", "restore in one cycle", 32'(cell_q), 32'(stored_vec));
    // activity without hold_load leaves the stored vector alone
    apply(1, 0, 0, '0, 1'b1, '0);
    apply(1, 0, 0, '0, 1'b0, '0);
    apply(0, 0, 0, 10'h3FF, 1'b0, '0);
    apply(1, 1, 0, '0, 1'b0, '0);
    check("R5", "vector kept without load", 32'(cell_q), 32'(stored_vec));
    // load during a shift stores the pre-shift values
    apply(1, 0, 1, '0, 1'b1, '0);
    check("R3", "shift alongside hold load", 32'(cell_q), 32'({stored_vec[N-2:0], 1'b1}));
    apply(0, 0, 0, '0, 1'b0, '0);
    apply(1, 1, 0, '0, 1'b0, '0);
    check("R5", "pre-edge values stored", 32'(cell_q), 32'(stored_vec));
  endtask

  task automatic t_repeat;
    for (int k = 0; k < 3; k++) begin
      logic [N-1:0] scramble;
      scramble = N'(10'h0A5 * (k + 3)) ^ 10'h2F0;
      apply(0, 0, 0, scramble, 1'b0, '0);
      check("R2", "scramble capture", 32'(cell_q), 32'(scramble));
      apply(1, 1, 0, '0, 1'b0, '0);
      check("R6", "repeated restore", 32'(cell_q), 32'(stored_vec));
    end
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "cells cleared by reset", 32'(cell_q), 0);
    rst_n = 1'b1;
    apply(1, 1, 0, '0, 1'b0, '0);
    check("R6", "restore after reset", 32'(cell_q), 32'(stored_vec));
  endtask

  task automatic t_clusters;
    logic [N-1:0] pats [5] = '{10'h008, 10'h080, 10'h200, 10'h3FF, 10'h177};
    foreach (pats[k]) begin
      logic [NCL-1:0] exp;
      apply(0, 0, 0, pats[k], 1'b0, '0);
      for (int c = 0; c < NCL; c++) begin
        int tail;
        tail = (c == NCL - 1) ? N - 1 : c * CS + CS - 1;
        exp[c] = pats[k][tail];
      end
      check("R7", "cluster tail responses", 32'(cluster_resp), 32'(exp));
    end
  endtask

  task automatic t_shared;
    logic [NS-1:0] pat;
    logic [NS-1:0] exp;
    pat = 6'b100110;
    apply(0, 0, 0, '0, 1'b0, pat);
    check("R2", "shared chain capture", 32'(cell_q_s), 32'(pat));
    apply(0, 0, 1, '0, 1'b0, 6'b111111);
    apply(1, 1, 0, '0, 1'b0, '0);
    for (int i = 0; i < NS; i++) exp[i] = pat[i - (i % 2)];
    check("R8", "shared hold restore", 32'(cell_q_s), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    stored_vec = 10'h2CE;
    t_functional();
    t_shift();
    t_hold_restore();
    t_repeat();
    t_clusters();
    t_shared();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule